// File: doc/BRIEF.md
# Polar Codeword Builder with Frozen and Parity Bit Insertion

This block turns a serial message into one polar codeword. A parameter set is loaded before each block, or kept from the block before. It holds a 3-bit length code, a frozen-position map and a parity-position map. Message bits arrive one per beat between a start-of-packet and an end-of-packet marker.

Once the packet ends, the block walks the codeword positions one per cycle in ascending order. Each position receives one of three values: zero if it is frozen, a parity value from a small cyclic register if it is flagged as a parity position, or the next message bit otherwise. The completed vector then passes through the polar butterfly transform. The codeword appears on a wide output bus together with a one-cycle valid strobe.

A packet whose bit count does not fill the message slots exactly produces an error strobe and no codeword. Parameters and data each use a ready/valid handshake with a ready latency of one cycle. A set of acceptance rules keeps a parameter load and a packet start apart in time.

Top module: `polar_insert_enc`

## Requirements
- R1: The length code selects N: 1 gives 32, 2 gives 64, 3 gives 128, 4 gives 256, 5 gives 512 and 6 gives 1024. The codeword is driven on outWord[N-1:0], and every bit of outWord at or above N is zero while outValid is high.
- R2: A position p below N with cfgFrozen[p]=1 holds a zero before the transform. Map bits at index N or higher have no effect on the codeword.
- R3: Message bits go, in arrival order, to the non-frozen positions that are not parity positions, in ascending position order. The first bit received goes to the lowest such position.
- R4: A 5-slot parity register is cleared at the start of every block. At each position below N, visited in ascending order, the register first rotates one slot toward slot 0, with the old slot 0 moving into slot 4. A parity position then takes the value of slot 0. At every non-frozen position, the bit placed there is XORed into slot 0 after the rotation.
- R5: Non-frozen positions are numbered 0, 1, 2 and so on in ascending order. Position k is a parity position when cfgParity[k]=1 and 1 <= k <= 27. Bit 0 of the map is never honoured, and map bits past the number of non-frozen positions have no effect.
- R6: Let u be the vector of placed bits. Codeword bit i is the XOR of u[j] over every j < N whose binary index contains all the one-bits of i, that is (j & i) == i.
- R7: After reset, cfgReq is high and no data beat is accepted until a parameter set has been captured. cfgReq falls only after a capture. Later blocks reuse the last captured set when no new one is given.
- R8: A parameter beat counts only when cfgValid is high, cfgReady was high in the previous cycle, and cfgValid was low in the previous cycle. If cfgValid is held high over several cycles, only the values of its first cycle are captured.
- R9: A data beat is ignored when cfgValid is high in the same cycle, when cfgValid was high in the previous cycle, or when a packet's end beat was accepted in the previous cycle.
- R10: While no packet is open, a data beat without inSop is ignored. A beat with inSop opens a packet, and the beat with inEop closes it.
- R11: When the number of message bits received differs from the number of message slots, outLenErr pulses for one cycle. In that case outValid stays low and outWord keeps its previous value.
- R12: outValid is a one-cycle pulse. It is high exactly N+2 cycles after the cycle in which the end beat was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| cfgReq | output | 1 | Parameters are required before any data |
| cfgReady | output | 1 | Parameters may be offered in the next cycle |
| cfgValid | input | 1 | Parameter beat valid |
| cfgLenCode | input | 3 | Length code (1..6 selects N = 32..1024) |
| cfgFrozen | input | MAX_N | Frozen-position map, bit p for position p |
| cfgParity | input | PC_W | Parity flag per non-frozen position index |
| inReady | output | 1 | A data beat may be offered in the next cycle |
| inValid | input | 1 | Data beat valid |
| inSop | input | 1 | First bit of a packet |
| inEop | input | 1 | Last bit of a packet |
| inBit | input | 1 | Message bit |
| outValid | output | 1 | Codeword valid, one-cycle pulse |
| outLenErr | output | 1 | Message length mismatch, one-cycle pulse |
| outWord | output | MAX_N | Codeword on bits [N-1:0] |

## Verification
Directed blocks cover five of the six lengths. They use frozen maps with stray bits above N and parity maps that set bit 0 and bits past the non-frozen count, so that the bit-ordering, parity-rotation and ignored-bit rules each change the expected codeword if broken. The bench also feeds a held parameter valid, parameter and data beats that collide, a stray beat right after an end beat, and beats without a start marker. Each of these cases shows whether the beat was dropped or taken by the codeword or length error that follows. Packets one bit short and one bit long separate the error path from normal completion.

// File: rtl/polar_ins_pkg.sv
package polar_ins_pkg;

  typedef enum logic [2:0] {
    ST_NEEDCFG,
    ST_IDLE,
    ST_RECV,
    ST_WALK,
    ST_EMIT
  } enc_state_t;

  // strobes from control to datapath
  typedef struct packed {
    logic cfgLoad;
    logic msgWrite;
    logic msgClear;
    logic walkInit;
    logic walkStep;
    logic finish;
  } ctrl_strobe_t;

  // log2 of the block length for a length code; codes outside 1..6 fall back to 32
  function automatic logic [3:0] lenLog2(input logic [2:0] code);
    logic [3:0] r;
    case (code)
      3'd1, 3'd2, 3'd3, 3'd4, 3'd5, 3'd6: r = 4'(code) + 4'd4;
      default: r = 4'd5;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/polar_ins_ctrl.sv
module polar_ins_ctrl
  import polar_ins_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         cfgValid,
  input  logic         inValid,
  input  logic         inSop,
  input  logic         inEop,
  input  logic         walkLast,
  output logic         cfgReq,
  output logic         cfgReady,
  output logic         inReady,
  output ctrl_strobe_t strb
);

  enc_state_t state, stateNext;
  logic cfgRdyD, inRdyD, cfgValidQ, eopTookQ;
  logic cfgTake, dataOk, beatTake;

  assign cfgReq   = (state == ST_NEEDCFG);
  assign cfgReady = (state == ST_NEEDCFG) || (state == ST_IDLE);
  assign inReady  = (state == ST_IDLE) || (state == ST_RECV);

  // ready latency of one: a beat counts only if ready was shown the cycle before
  assign cfgTake  = cfgValid && !cfgValidQ && cfgRdyD && cfgReady;
  assign dataOk   = inValid && inRdyD && inReady && !cfgValid && !cfgValidQ && !eopTookQ;
  assign beatTake = dataOk && ((state == ST_RECV) || inSop);

  always_comb begin
    strb          = '0;
    strb.cfgLoad  = cfgTake;
    strb.msgWrite = beatTake;
    strb.msgClear = beatTake && inSop;
    strb.walkInit = beatTake && inEop;
    strb.walkStep = (state == ST_WALK);
    strb.finish   = (state == ST_EMIT);
  end

  always_comb begin
    stateNext = state;
    case (state)
      ST_NEEDCFG: if (cfgTake) stateNext = ST_IDLE;
      ST_IDLE:    if (beatTake) stateNext = inEop ? ST_WALK : ST_RECV;
      ST_RECV:    if (beatTake && inEop) stateNext = ST_WALK;
      ST_WALK:    if (walkLast) stateNext = ST_EMIT;
      ST_EMIT:    stateNext = ST_IDLE;
      default:    stateNext = ST_NEEDCFG;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_NEEDCFG;
      cfgRdyD   <= 1'b0;
      inRdyD    <= 1'b0;
      cfgValidQ <= 1'b0;
      eopTookQ  <= 1'b0;
    end else begin
      state     <= stateNext;
      cfgRdyD   <= cfgReady;
      inRdyD    <= inReady;
      cfgValidQ <= cfgValid;
      eopTookQ  <= beatTake && inEop;
    end
  end

  AST_CFG_SINGLE_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    strb.cfgLoad |=> !strb.cfgLoad); // R8
  AST_NO_BEAT_AFTER_EOP: assert property (@(posedge clk) disable iff (!rstN)
    strb.walkInit |=> !strb.msgWrite); // R9
  AST_REQ_DROPS_ON_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    $fell(cfgReq) |-> $past(strb.cfgLoad)); // R7
  AST_NO_BEAT_AFTER_CFG: assert property (@(posedge clk) disable iff (!rstN)
    strb.cfgLoad |=> !strb.msgWrite); // R9

endmodule

// File: rtl/polar_ins_dpath.sv
module polar_ins_dpath
  import polar_ins_pkg::*;
#(
  parameter int MAX_N  = 1024,
  parameter int PC_W   = 28,
  parameter int PREG_W = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrl_strobe_t       strb,
  input  logic [2:0]         cfgLenCode,
  input  logic [MAX_N-1:0]   cfgFrozen,
  input  logic [PC_W-1:0]    cfgParity,
  input  logic               inBit,
  output logic               walkLast,
  output logic               outValid,
  output logic               outLenErr,
  output logic [MAX_N-1:0]   outWord
);

  localparam int LOGN = $clog2(MAX_N);
  localparam int CW   = LOGN + 1;
  localparam int PCIW = $clog2(PC_W);
  localparam int PPW  = 1 << PCIW;

  // bit i is set when index bit h of i is clear (butterfly upper lanes)
  function automatic logic [MAX_N-1:0] stageMask(input int h);
    logic [MAX_N-1:0] m;
    for (int i = 0; i < MAX_N; i++) m[i] = ((i & h) == 0);
    return m;
  endfunction

  logic [3:0]        lenLogQ;
  logic [MAX_N-1:0]  frozenQ;
  logic [PC_W-1:0]   parityQ;
  logic [MAX_N-1:0]  msgBuf;
  logic [CW-1:0]     msgCnt;
  logic              msgOvf;
  logic [CW-1:0]     pos, infoIdx, msgPtr;
  logic [PREG_W-1:0] parReg, parRot;
  logic [MAX_N-1:0]  uVec;

  logic [CW-1:0]     nLen, wrIdx;
  logic [LOGN-1:0]   posIdx;
  logic [PPW-1:0]    parPad;
  logic              infoHit, parHit, msgBit, placeBit, lenBad;
  logic [3:0]        lenLogNew;
  logic [MAX_N-1:0]  lowMask;

  assign lenLogNew = (lenLog2(cfgLenCode) > 4'(LOGN)) ? 4'(LOGN) : lenLog2(cfgLenCode);
  assign nLen      = CW'(1) << lenLogQ;
  assign walkLast  = (pos == nLen - CW'(1));
  assign posIdx    = pos[LOGN-1:0];
  assign parPad    = PPW'(parityQ);
  assign infoHit   = !frozenQ[posIdx];
  assign parHit    = infoHit && (infoIdx != '0) && (infoIdx < CW'(PC_W))
                     && parPad[infoIdx[PCIW-1:0]];
  assign parRot    = {parReg[0], parReg[PREG_W-1:1]};
  assign msgBit    = (msgPtr < CW'(MAX_N)) ? msgBuf[msgPtr[LOGN-1:0]] : 1'b0;
  assign placeBit  = !infoHit ? 1'b0 : (parHit ? parRot[0] : msgBit);
  assign lenBad    = msgOvf || (msgPtr != msgCnt);
  assign wrIdx     = strb.msgClear ? '0 : msgCnt;
  assign lowMask   = ~({MAX_N{1'b1}} << nLen);

  // butterfly network: stage s pairs lanes i and i + 2**s
  logic [MAX_N-1:0] xfStage [0:LOGN];
  assign xfStage[0] = uVec;
  for (genvar s = 0; s < LOGN; s++) begin : g_xf
    localparam logic [MAX_N-1:0] LaneMask = stageMask(1 << s);
    assign xfStage[s+1] = xfStage[s] ^ ((xfStage[s] >> (1 << s)) & LaneMask);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lenLogQ   <= 4'd5;
      frozenQ   <= '0;
      parityQ   <= '0;
      msgBuf    <= '0;
      msgCnt    <= '0;
      msgOvf    <= 1'b0;
      pos       <= '0;
      infoIdx   <= '0;
      msgPtr    <= '0;
      parReg    <= '0;
      uVec      <= '0;
      outValid  <= 1'b0;
      outLenErr <= 1'b0;
      outWord   <= '0;
    end else begin
      if (strb.cfgLoad) begin
        lenLogQ <= lenLogNew;
        frozenQ <= cfgFrozen;
        parityQ <= cfgParity;
      end
      if (strb.msgWrite) begin
        if (strb.msgClear) msgOvf <= 1'b0;
        if (wrIdx < CW'(MAX_N)) begin
          msgBuf[wrIdx[LOGN-1:0]] <= inBit;
          msgCnt <= wrIdx + CW'(1);
        end else begin
          msgOvf <= 1'b1;
        end
      end
      if (strb.walkInit) begin
        pos     <= '0;
        infoIdx <= '0;
        msgPtr  <= '0;
        parReg  <= '0;
        uVec    <= '0;
      end else if (strb.walkStep) begin
        uVec[posIdx] <= placeBit;
        pos          <= pos + CW'(1);
        infoIdx      <= infoIdx + CW'(infoHit);
        msgPtr       <= msgPtr + CW'(infoHit && !parHit);
        parReg       <= parRot ^ {{(PREG_W-1){1'b0}}, placeBit};
      end
      outValid  <= 1'b0;
      outLenErr <= 1'b0;
      if (strb.finish) begin
        if (lenBad) begin
          outLenErr <= 1'b1;
        end else begin
          outValid <= 1'b1;
          outWord  <= xfStage[LOGN];
        end
      end
    end
  end

  AST_ERR_EXCLUDES_VALID: assert property (@(posedge clk) disable iff (!rstN)
    !(outValid && outLenErr)); // R11
  AST_ERR_KEEPS_WORD: assert property (@(posedge clk) disable iff (!rstN)
    outLenErr |-> $stable(outWord)); // R11
  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    outValid |=> !outValid); // R12
  AST_UPPER_BITS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> ((outWord & ~lowMask) == '0)); // R1

endmodule

// File: rtl/polar_insert_enc.sv
module polar_insert_enc
  import polar_ins_pkg::*;
#(
  parameter int MAX_N  = 1024,
  parameter int PC_W   = 28,
  parameter int PREG_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  output logic             cfgReq,
  output logic             cfgReady,
  input  logic             cfgValid,
  input  logic [2:0]       cfgLenCode,
  input  logic [MAX_N-1:0] cfgFrozen,
  input  logic [PC_W-1:0]  cfgParity,
  output logic             inReady,
  input  logic             inValid,
  input  logic             inSop,
  input  logic             inEop,
  input  logic             inBit,
  output logic             outValid,
  output logic             outLenErr,
  output logic [MAX_N-1:0] outWord
);

  ctrl_strobe_t strb;
  logic walkLast;

  polar_ins_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cfgValid (cfgValid),
    .inValid  (inValid),
    .inSop    (inSop),
    .inEop    (inEop),
    .walkLast (walkLast),
    .cfgReq   (cfgReq),
    .cfgReady (cfgReady),
    .inReady  (inReady),
    .strb     (strb)
  );

  polar_ins_dpath #(
    .MAX_N  (MAX_N),
    .PC_W   (PC_W),
    .PREG_W (PREG_W)
  ) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .cfgLenCode (cfgLenCode),
    .cfgFrozen  (cfgFrozen),
    .cfgParity  (cfgParity),
    .inBit      (inBit),
    .walkLast   (walkLast),
    .outValid   (outValid),
    .outLenErr  (outLenErr),
    .outWord    (outWord)
  );

endmodule

// File: tb/polar_insert_enc_test.sv
module polar_insert_enc_test;

  localparam int CLK_PERIOD = 10;
  localparam int MAXN = 1024;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgReq, cfgReady, inReady, outValid, outLenErr;
  logic cfgValid = 1'b0;
  logic [2:0] cfgLenCode = '0;
  logic [MAXN-1:0] cfgFrozen = '0;
  logic [27:0] cfgParity = '0;
  logic inValid = 1'b0, inSop = 1'b0, inEop = 1'b0, inBit = 1'b0;
  logic [MAXN-1:0] outWord;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  logic msgArr [0:MAXN-1];
  int lcg = 32'h1234_5678;

  always #(CLK_PERIOD/2) clk = ~clk;

  polar_insert_enc uut (
    .clk(clk), .rstN(rstN), .cfgReq(cfgReq), .cfgReady(cfgReady),
    .cfgValid(cfgValid), .cfgLenCode(cfgLenCode), .cfgFrozen(cfgFrozen),
    .cfgParity(cfgParity), .inReady(inReady), .inValid(inValid),
    .inSop(inSop), .inEop(inEop), .inBit(inBit), .outValid(outValid),
    .outLenErr(outLenErr), .outWord(outWord)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [MAXN-1:0] act, input logic [MAXN-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic int slotCount(int n, logic [MAXN-1:0] frz, logic [27:0] pc);
    int info = 0, cnt = 0;
    for (int p = 0; p < n; p++) begin
      if (!frz[p]) begin
        if (!(info > 0 && info < 28 && pc[info])) cnt++;
        info++;
      end
    end
    return cnt;
  endfunction

  // independent reference: placement with parity register, then superset-XOR transform
  function automatic logic [MAXN-1:0] refWord(int n, logic [MAXN-1:0] frz, logic [27:0] pc);
    logic [MAXN-1:0] u = '0;
    logic [MAXN-1:0] x = '0;
    logic [4:0] y = '0;
    int info = 0, mp = 0;
    logic b, t;
    for (int p = 0; p < n; p++) begin
      t = y[0];
      y = {t, y[4:1]};
      if (!frz[p]) begin
        if (info > 0 && info < 28 && pc[info]) b = y[0];
        else begin
          b = (mp < MAXN) ? msgArr[mp] : 1'b0;
          mp++;
        end
        y[0] = y[0] ^ b;
        u[p] = b;
        info++;
      end
    end
    for (int i = 0; i < n; i++) begin
      b = 1'b0;
      for (int j = i; j < n; j++) if ((j & i) == i) b = b ^ u[j];
      x[i] = b;
    end
    return x;
  endfunction

  task automatic genMsg(input int len);
    for (int i = 0; i < MAXN; i++) begin
      lcg = lcg * 1103515245 + 12345;
      msgArr[i] = (i < len) ? lcg[16] : 1'b0;
    end
  endtask

  task automatic applyCfg(input logic [2:0] code, input logic [MAXN-1:0] frz, input logic [27:0] pc);
    do @(negedge clk); while (!cfgReady);
    @(negedge clk);
    cfgValid = 1'b1; cfgLenCode = code; cfgFrozen = frz; cfgParity = pc;
    @(negedge clk);
    cfgValid = 1'b0;
  endtask

  // sends len bits; optional stray beat right after the end beat; measures latency
  task automatic runBlock(input int len, input bit stray, output int lat,
                          output bit gotV, output bit gotE);
    do @(negedge clk); while (!inReady);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      inValid = 1'b1; inSop = (i == 0); inEop = (i == len - 1); inBit = msgArr[i];
    end
    lat = 0; gotV = 0; gotE = 0;
    while (lat < 1200) begin
      @(negedge clk);
      if (lat == 0 && stray) begin
        inValid = 1'b1; inSop = 1'b1; inEop = 1'b1; inBit = 1'b1;
      end else begin
        inValid = 1'b0; inSop = 1'b0; inEop = 1'b0;
      end
      lat++;
      if (outValid) gotV = 1;
      if (outLenErr) gotE = 1;
      if (gotV || gotE) break;
    end
  endtask

  task automatic quietFor(input int cycles, input string req, input string what);
    bit seen = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (outValid || outLenErr) seen = 1;
    end
    check(!seen, req, what, MAXN'(seen), '0);
  endtask

  task automatic goodBlock(input int n, input logic [MAXN-1:0] frz, input logic [27:0] pc,
                           input bit stray, input string req);
    int lat; bit v, e;
    logic [MAXN-1:0] exp;
    genMsg(slotCount(n, frz, pc));
    exp = refWord(n, frz, pc);
    runBlock(slotCount(n, frz, pc), stray, lat, v, e);
    check(v && !e, req, "codeword strobe", MAXN'({v, e}), MAXN'(2));
    check(outWord === exp, req, "codeword", outWord, exp);
    check(lat == n + 2, "R12", "latency", MAXN'(lat), MAXN'(n + 2));
  endtask

  task automatic t_reset;
    check(cfgReq === 1'b1, "R7", "cfgReq after reset", MAXN'(cfgReq), MAXN'(1));
    check(inReady === 1'b0, "R7", "inReady after reset", MAXN'(inReady), '0);
    check(outValid === 1'b0, "R12", "outValid after reset", MAXN'(outValid), '0);
    @(negedge clk);
    inValid = 1'b1; inSop = 1'b1; inEop = 1'b1;
    @(negedge clk);
    inValid = 1'b0; inSop = 1'b0; inEop = 1'b0;
    quietFor(60, "R7", "beat before parameters");
    check(cfgReq === 1'b1, "R7", "cfgReq still high", MAXN'(cfgReq), MAXN'(1));
  endtask

  task automatic t_basic32;
    logic [MAXN-1:0] frz = '0;
    frz[31:0] = 32'h0F17_0357;
    frz[200] = 1'b1; frz[900] = 1'b1; frz[40] = 1'b1;  // above N: R2 ignored bits
    applyCfg(3'd1, frz, '0);
    check(cfgReq === 1'b0, "R7", "cfgReq after capture", MAXN'(cfgReq), '0);
    goodBlock(32, frz, '0, 0, "R1 R2 R3 R6");
  endtask

  task automatic t_parity64;
    logic [MAXN-1:0] frz = '0;
    logic [27:0] pc = 28'hF00_0000 | 28'h0A5_2C1;  // bit 0 set and high bits past count: R5
    frz[63:0] = 64'hFF0F_37F1_0F7F_FFFF;
    applyCfg(3'd2, frz, pc);
    goodBlock(64, frz, pc, 0, "R4 R5");
    goodBlock(64, frz, pc, 0, "R7 reuse");
  endtask

  task automatic t_mid;
    logic [MAXN-1:0] frz = '0;
    for (int i = 0; i < 128; i++) frz[i] = (i < 70) || (i % 7 == 3);
    applyCfg(3'd3, frz, 28'h924_9A5A);
    goodBlock(128, frz, 28'h924_9A5A, 0, "R1 R4 R5 N=128");
    frz = '0;
    for (int i = 0; i < 512; i++) frz[i] = (i < 400) || (i % 5 == 0);
    applyCfg(3'd5, frz, 28'h0C3_0F06);
    goodBlock(512, frz, 28'h0C3_0F06, 0, "R1 R6 N=512");
  endtask

  task automatic t_big1024;
    logic [MAXN-1:0] frz = '0;
    for (int i = 0; i < MAXN; i++) frz[i] = (i < 600) || (i % 9 == 4);
    applyCfg(3'd6, frz, 28'h555_0AA6);
    goodBlock(1024, frz, 28'h555_0AA6, 0, "R1 R6 N=1024");
  endtask

  task automatic t_mismatch;
    logic [MAXN-1:0] frz = '0;
    logic [MAXN-1:0] prev;
    int lat; bit v, e; int s;
    frz[31:0] = 32'h00FF_0F0F;
    applyCfg(3'd1, frz, '0);
    s = slotCount(32, frz, '0);
    goodBlock(32, frz, '0, 0, "R11 setup");
    prev = outWord;
    genMsg(s - 1);
    runBlock(s - 1, 0, lat, v, e);
    check(e && !v, "R11", "short packet error", MAXN'({v, e}), MAXN'(1));
    check(outWord === prev, "R11", "word held on short", outWord, prev);
    genMsg(s + 1);
    runBlock(s + 1, 0, lat, v, e);
    check(e && !v, "R11", "long packet error", MAXN'({v, e}), MAXN'(1));
    check(outWord === prev, "R11", "word held on long", outWord, prev);
  endtask

  task automatic t_hold;
    logic [MAXN-1:0] frzA = '0;
    logic [MAXN-1:0] frzB = '0;
    frzA[63:0] = 64'hF0F0_FF00_3C3C_0FFF;
    frzB[31:0] = 32'h1;
    do @(negedge clk); while (!cfgReady);
    @(negedge clk);
    cfgValid = 1'b1; cfgLenCode = 3'd2; cfgFrozen = frzA; cfgParity = 28'h0000_0A4;
    @(negedge clk);
    cfgLenCode = 3'd1; cfgFrozen = frzB; cfgParity = '0;
    @(negedge clk);
    @(negedge clk);
    cfgValid = 1'b0;
    goodBlock(64, frzA, 28'h0000_0A4, 0, "R8 first cycle only");
  endtask

  task automatic t_collide;
    logic [MAXN-1:0] frz = '0;
    frz[31:0] = 32'hC3A5_0F11;
    do @(negedge clk); while (!(cfgReady && inReady));
    @(negedge clk);
    cfgValid = 1'b1; cfgLenCode = 3'd1; cfgFrozen = frz; cfgParity = 28'h0000_014;
    inValid = 1'b1; inSop = 1'b1; inEop = 1'b1;
    @(negedge clk);
    cfgValid = 1'b0;  // beat again, right after cfgValid
    @(negedge clk);
    inValid = 1'b0; inSop = 1'b0; inEop = 1'b0;
    quietFor(60, "R9", "beats beside parameters");
    goodBlock(32, frz, 28'h0000_014, 1, "R9 params taken, stray after end");
    quietFor(60, "R9", "stray beat after end");
  endtask

  task automatic t_framing;
    logic [MAXN-1:0] frz = '0;
    frz[31:0] = 32'h0F0F_0033;
    applyCfg(3'd1, frz, 28'h0000_00A);
    @(negedge clk);
    inValid = 1'b1; inSop = 1'b0; inEop = 1'b1; inBit = 1'b1;
    for (int i = 0; i < 3; i++) @(negedge clk);
    inValid = 1'b0; inEop = 1'b0;
    quietFor(50, "R10", "beats without start");
    goodBlock(32, frz, 28'h0000_00A, 0, "R10 framing");
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 5; i++) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic32();
    t_parity64();
    t_mid();
    t_big1024();
    t_mismatch();
    t_hold();
    t_collide();
    t_framing();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule